// File: doc/BRIEF.md
# Legacy Chip-Select Decoder with Reset Straps

This block sits behind an ISA-style address bus and turns address and strobe activity into active-low chip selects for the classic fixed-address devices. Those devices are a POST code port, a keyboard controller, a mouse controller, a real-time clock, a catch-all low I/O window and the boot ROM. It also flags accesses to the index/data pair of the configuration register space. All decoding is combinational, so a select follows the address and strobes within the same bus phase.

Four board straps are sampled while reset is held. They choose which optional decodes exist and where the configuration port lives. Once reset is released the captured values stay frozen until the next reset, whatever the pins do later. Two live configuration bits add the low I/O window and a software override for the ROM select.

Top module: `legacy_cs_decoder`

## Requirements
- R1: While `rst_n` is low, every `*_cs_n` output is 1 and `cfg_port_hit` is 0, regardless of address and strobes.
- R2: Strap pins are captured on each rising clock edge at which `rst_n` is sampled low. The value from the last such edge is held until `rst_n` goes low again, and strap pin changes after reset release have no effect on any output.
- R3: With the keyboard strap captured low, an I/O access to 0060h or 0064h drives `kb_cs_n` low, and one to 0062h or 0066h drives `mc_cs_n` low.
- R4: With the keyboard strap captured high, `kb_cs_n` and `mc_cs_n` stay high and an I/O access to 0080h drives `p80_cs_n` low. With it captured low, `p80_cs_n` never asserts.
- R5: With the RTC strap captured low, an I/O access to 0070h or 0071h drives `rtc_cs_n` low. With it captured high, `rtc_cs_n` stays high.
- R6: When `cfg_lowio_en` is 1, an I/O access whose address bits 15:11 are all zero drives `lowio_cs_n` low, alongside any fixed-port select. Otherwise `lowio_cs_n` stays high.
- R7: `cfg_port_hit` goes to 1 for an I/O access to 004Eh or 004Fh when the config-port strap was captured high, and to 002Eh or 002Fh when it was captured low.
- R8: `rom_cs_n` goes low when `memr_n` is low and `sa` lies in F0000h..FFFFFh, provided that `cfg_rom_en` is 1 or the ROM strap was captured high.
- R9: An I/O select or `cfg_port_hit` asserts only when `aen` is 0 and `ior_n` or `iow_n` is 0. The compare covers all 16 I/O address bits, so 1060h does not select the keyboard.
- R10: `rom_cs_n` ignores I/O strobes. An I/O access whose address falls in the ROM window leaves `rom_cs_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the straps |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_kb_n | input | 1 | Keyboard strap, low enables keyboard/mouse selects |
| strap_rtc_n | input | 1 | RTC strap, low enables the RTC select |
| strap_cfg_hi | input | 1 | Config port strap, 1 selects 4Eh, 0 selects 2Eh |
| strap_rom_en | input | 1 | ROM select strap, 1 enables the ROM select |
| sa | input | 20 | System address |
| aen | input | 1 | Address enable, high during DMA |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| cfg_rom_en | input | 1 | Software ROM select enable |
| cfg_lowio_en | input | 1 | Software low I/O window enable |
| p80_cs_n | output | 1 | POST code port select |
| kb_cs_n | output | 1 | Keyboard controller select |
| mc_cs_n | output | 1 | Mouse controller select |
| rtc_cs_n | output | 1 | Real-time clock select |
| lowio_cs_n | output | 1 | Low I/O window select |
| rom_cs_n | output | 1 | Boot ROM select |
| cfg_port_hit | output | 1 | Access to configuration index/data ports |

## Verification
The hardest condition to reach is a strap pin that changes after reset release. From the ports it looks the same as a correctly held strap unless the decode that the strap governs is probed afterwards. Each scenario therefore resets with a chosen strap set and inverts every strap pin one cycle after release. It then probes the keyboard, RTC, config and ROM addresses, so a latch that keeps tracking its pin shows up as a wrong select. A second reset with the opposite straps shows that a fresh capture does take place.

// File: rtl/legacy_cs_pkg.sv
package legacy_cs_pkg;

   // Captured board straps, all active-high meaning "feature on"
   typedef struct packed {
      logic kb_en;
      logic rtc_en;
      logic cfg_hi;
      logic rom_en;
   } strap_t;

   // Internal active-high I/O hits
   typedef struct packed {
      logic p80;
      logic kb;
      logic mc;
      logic rtc;
      logic lowio;
      logic cfg;
   } io_hit_t;

   localparam int unsigned IO_HIT_N = 6;

endpackage

// File: rtl/strap_capture.sv
module strap_capture
   import legacy_cs_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin_kb_n,
   input  logic   pin_rtc_n,
   input  logic   pin_cfg_hi,
   input  logic   pin_rom_en,
   output strap_t straps
);

   strap_t pin_view;

   always_comb begin
      pin_view.kb_en  = ~pin_kb_n;
      pin_view.rtc_en = ~pin_rtc_n;
      pin_view.cfg_hi = pin_cfg_hi;
      pin_view.rom_en = pin_rom_en;
   end

   // Track the pins on every edge seen in reset; freeze afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         straps <= pin_view;
      end
   end

   // R2: straps frozen while out of reset
   a_r2_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(straps));

endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
   import legacy_cs_pkg::*;
#(
   parameter int unsigned       IO_W       = 16,
   parameter logic [IO_W-1:0]   PORT_P80   = 16'h0080,
   parameter logic [IO_W-1:0]   PORT_KB_A  = 16'h0060,
   parameter logic [IO_W-1:0]   PORT_KB_B  = 16'h0064,
   parameter logic [IO_W-1:0]   PORT_MC_A  = 16'h0062,
   parameter logic [IO_W-1:0]   PORT_MC_B  = 16'h0066,
   parameter logic [IO_W-1:0]   PORT_RTC   = 16'h0070,
   parameter logic [IO_W-1:0]   PORT_CFG_H = 16'h004E,
   parameter logic [IO_W-1:0]   PORT_CFG_L = 16'h002E,
   parameter int unsigned       LOWIO_LSB  = 11,
   parameter bit                RTC_PAIR   = 1'b1,
   parameter bit                CFG_PAIR   = 1'b1
) (
   input  logic [IO_W-1:0] io_addr,
   input  logic            io_cyc,
   input  logic            lowio_en,
   input  strap_t          straps,
   output io_hit_t         hits
);

   localparam int unsigned ZERO_W = IO_W - LOWIO_LSB;

   generate
      if (IO_W < 8 || IO_W > 32) begin : g_bad_iow
         $error("io_port_decoder: IO_W out of range");
      end
      if (LOWIO_LSB >= IO_W) begin : g_bad_lowio
         $error("io_port_decoder: LOWIO_LSB must be below IO_W");
      end
      if (RTC_PAIR && PORT_RTC[0]) begin : g_bad_rtc
         $error("io_port_decoder: paired RTC base must be even");
      end
      if (CFG_PAIR && (PORT_CFG_H[0] || PORT_CFG_L[0])) begin : g_bad_cfg
         $error("io_port_decoder: paired config bases must be even");
      end
   endgenerate

   logic hit_p80, hit_kb, hit_mc, hit_rtc, hit_cfg, hit_low;
   logic [IO_W-1:0] cfg_base;

   assign cfg_base = straps.cfg_hi ? PORT_CFG_H : PORT_CFG_L;

   assign hit_p80 = (io_addr == PORT_P80);
   assign hit_kb  = (io_addr == PORT_KB_A) || (io_addr == PORT_KB_B);
   assign hit_mc  = (io_addr == PORT_MC_A) || (io_addr == PORT_MC_B);
   assign hit_low = (io_addr[IO_W-1:LOWIO_LSB] == {ZERO_W{1'b0}});

   // Paired ports ignore address bit 0; single ports compare all bits
   generate
      if (RTC_PAIR) begin : g_rtc_pair
         assign hit_rtc = (io_addr[IO_W-1:1] == PORT_RTC[IO_W-1:1]);
      end else begin : g_rtc_single
         assign hit_rtc = (io_addr == PORT_RTC);
      end
      if (CFG_PAIR) begin : g_cfg_pair
         assign hit_cfg = (io_addr[IO_W-1:1] == cfg_base[IO_W-1:1]);
      end else begin : g_cfg_single
         assign hit_cfg = (io_addr == cfg_base);
      end
   endgenerate

   always_comb begin
      hits.p80   = io_cyc & hit_p80 & ~straps.kb_en;
      hits.kb    = io_cyc & hit_kb  &  straps.kb_en;
      hits.mc    = io_cyc & hit_mc  &  straps.kb_en;
      hits.rtc   = io_cyc & hit_rtc &  straps.rtc_en;
      hits.lowio = io_cyc & hit_low &  lowio_en;
      hits.cfg   = io_cyc & hit_cfg;
   end

   // R4: with keyboard on, the POST port select is never produced
   a_r4_p80_vs_kb: assert final (!(straps.kb_en === 1'b1 && hits.p80 === 1'b1));

endmodule

// File: rtl/rom_window_decoder.sv
module rom_window_decoder #(
   parameter int unsigned        ADDR_W = 20,
   parameter logic [ADDR_W-1:0]  ROM_LO = 20'hF0000,
   parameter logic [ADDR_W-1:0]  ROM_HI = 20'hFFFFF
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              mem_rd,
   input  logic              enable,
   output logic              rom_hit
);

   localparam longint unsigned SPAN    = longint'(ROM_HI) - longint'(ROM_LO) + 64'd1;
   localparam bit              POW2    = ((SPAN & (SPAN - 64'd1)) == 64'd0);
   localparam bit              ALIGNED = POW2 && ((longint'(ROM_LO) % SPAN) == 64'd0);
   localparam logic [ADDR_W-1:0] MASK  = ~(ADDR_W'(SPAN - 64'd1));

   generate
      if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_aw
         $error("rom_window_decoder: ADDR_W out of range");
      end
      if (ROM_HI < ROM_LO) begin : g_bad_range
         $error("rom_window_decoder: ROM_HI below ROM_LO");
      end
   endgenerate

   logic in_window;

   // Aligned power-of-two windows need one masked compare; others a range check
   generate
      if (ALIGNED) begin : g_masked
         assign in_window = ((addr & MASK) == ROM_LO);
      end else begin : g_range
         assign in_window = (addr >= ROM_LO) && (addr <= ROM_HI);
      end
   endgenerate

   assign rom_hit = mem_rd & enable & in_window;

endmodule

// File: rtl/legacy_cs_decoder.sv
module legacy_cs_decoder
   import legacy_cs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned IO_W     = 16,
   parameter bit          CFG_PAIR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_kb_n,
   input  logic              strap_rtc_n,
   input  logic              strap_cfg_hi,
   input  logic              strap_rom_en,
   input  logic [ADDR_W-1:0] sa,
   input  logic              aen,
   input  logic              ior_n,
   input  logic              iow_n,
   input  logic              memr_n,
   input  logic              cfg_rom_en,
   input  logic              cfg_lowio_en,
   output logic              p80_cs_n,
   output logic              kb_cs_n,
   output logic              mc_cs_n,
   output logic              rtc_cs_n,
   output logic              lowio_cs_n,
   output logic              rom_cs_n,
   output logic              cfg_port_hit
);

   generate
      if (IO_W > ADDR_W) begin : g_bad_widths
         $error("legacy_cs_decoder: IO_W exceeds ADDR_W");
      end
   endgenerate

   strap_t  straps;
   io_hit_t io_hits;
   logic    io_cyc;
   logic    mem_rd;
   logic    rom_en_any;
   logic    rom_hit;

   strap_capture u_straps (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_kb_n   (strap_kb_n),
      .pin_rtc_n  (strap_rtc_n),
      .pin_cfg_hi (strap_cfg_hi),
      .pin_rom_en (strap_rom_en),
      .straps     (straps)
   );

   assign io_cyc     = rst_n & ~aen & (~ior_n | ~iow_n);
   assign mem_rd     = rst_n & ~memr_n;
   assign rom_en_any = cfg_rom_en | straps.rom_en;

   io_port_decoder #(
      .IO_W     (IO_W),
      .CFG_PAIR (CFG_PAIR)
   ) u_io (
      .io_addr  (sa[IO_W-1:0]),
      .io_cyc   (io_cyc),
      .lowio_en (cfg_lowio_en),
      .straps   (straps),
      .hits     (io_hits)
   );

   rom_window_decoder #(
      .ADDR_W (ADDR_W)
   ) u_rom (
      .addr    (sa),
      .mem_rd  (mem_rd),
      .enable  (rom_en_any),
      .rom_hit (rom_hit)
   );

   assign p80_cs_n     = ~io_hits.p80;
   assign kb_cs_n      = ~io_hits.kb;
   assign mc_cs_n      = ~io_hits.mc;
   assign rtc_cs_n     = ~io_hits.rtc;
   assign lowio_cs_n   = ~io_hits.lowio;
   assign cfg_port_hit =  io_hits.cfg;
   assign rom_cs_n     = ~rom_hit;

   // R1: quiet outputs in reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (p80_cs_n && kb_cs_n && mc_cs_n && rtc_cs_n && lowio_cs_n
                  && rom_cs_n && !cfg_port_hit));

   // R9: no I/O select without an I/O strobe and with AEN low
   a_r9_io_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      (aen || (ior_n && iow_n)) |-> (p80_cs_n && kb_cs_n && mc_cs_n && rtc_cs_n
                                     && lowio_cs_n && !cfg_port_hit));

   // R10: ROM select only on memory reads
   a_r10_rom_mem_only: assert property (@(posedge clk) disable iff (!rst_n)
      memr_n |-> rom_cs_n);

   // R3/R4/R5/R7: fixed-port selects are mutually exclusive
   a_r3_fixed_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~p80_cs_n, ~kb_cs_n, ~mc_cs_n, ~rtc_cs_n, cfg_port_hit}));

   // R2: a strap pin toggling after release leaves the keyboard decode fixed
   a_r2_kb_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$stable(strap_kb_n)) |-> $stable(straps.kb_en));

endmodule

// File: tb/legacy_cs_decoder_tb.sv
module legacy_cs_decoder_tb;

   localparam int CLK_PERIOD = 10;

   // Output vector order: {p80, kb, mc, rtc, lowio, rom, cfg_hit}
   localparam logic [6:0] V_IDLE = 7'b1111110;
   localparam logic [6:0] V_P80  = 7'b0111110;
   localparam logic [6:0] V_KB   = 7'b1011110;
   localparam logic [6:0] V_MC   = 7'b1101110;
   localparam logic [6:0] V_RTC  = 7'b1110110;
   localparam logic [6:0] V_LOW  = 7'b1111010;
   localparam logic [6:0] V_ROM  = 7'b1111100;
   localparam logic [6:0] V_CFG  = 7'b1111111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_kb_n = 1'b1, strap_rtc_n = 1'b1, strap_cfg_hi = 1'b1, strap_rom_en = 1'b1;
   logic [19:0] sa = '0;
   logic        aen = 1'b0, ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1;
   logic        cfg_rom_en = 1'b0, cfg_lowio_en = 1'b0;
   logic        p80_cs_n, kb_cs_n, mc_cs_n, rtc_cs_n, lowio_cs_n, rom_cs_n, cfg_port_hit;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   legacy_cs_decoder u_dut (
      .clk(clk), .rst_n(rst_n),
      .strap_kb_n(strap_kb_n), .strap_rtc_n(strap_rtc_n),
      .strap_cfg_hi(strap_cfg_hi), .strap_rom_en(strap_rom_en),
      .sa(sa), .aen(aen), .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n),
      .cfg_rom_en(cfg_rom_en), .cfg_lowio_en(cfg_lowio_en),
      .p80_cs_n(p80_cs_n), .kb_cs_n(kb_cs_n), .mc_cs_n(mc_cs_n),
      .rtc_cs_n(rtc_cs_n), .lowio_cs_n(lowio_cs_n), .rom_cs_n(rom_cs_n),
      .cfg_port_hit(cfg_port_hit)
   );

   function automatic logic [6:0] outs();
      return {p80_cs_n, kb_cs_n, mc_cs_n, rtc_cs_n, lowio_cs_n, rom_cs_n, cfg_port_hit};
   endfunction

   task automatic check(input string req, input string what, input logic [6:0] exp);
      logic [6:0] act;
      act = outs();
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic bus_idle();
      aen = 1'b0; ior_n = 1'b1; iow_n = 1'b1; memr_n = 1'b1;
   endtask

   // Drive an access at the falling edge and sample 2 ns later
   task automatic access(input logic [19:0] a, input logic a_en,
                         input logic rd_n, input logic wr_n, input logic mr_n);
      @(negedge clk);
      sa = a; aen = a_en; ior_n = rd_n; iow_n = wr_n; memr_n = mr_n;
      #2;
   endtask

   task automatic io_rd(input logic [19:0] a); access(a, 1'b0, 1'b0, 1'b1, 1'b1); endtask
   task automatic io_wr(input logic [19:0] a); access(a, 1'b0, 1'b1, 1'b0, 1'b1); endtask
   task automatic mem_rd(input logic [19:0] a); access(a, 1'b0, 1'b1, 1'b1, 1'b0); endtask

   // Reset with given straps, probe quietness in reset (R1), release,
   // then invert every strap pin to stress the hold (R2)
   task automatic reset_with(input logic kb_n, input logic rtc_n,
                             input logic cfg_hi, input logic rom);
      @(negedge clk);
      rst_n = 1'b0;
      strap_kb_n = kb_n; strap_rtc_n = rtc_n; strap_cfg_hi = cfg_hi; strap_rom_en = rom;
      repeat (2) @(posedge clk);
      io_rd(20'h00060);
      check("R1", "io read in reset", V_IDLE);
      mem_rd(20'hF0000);
      check("R1", "mem read in reset", V_IDLE);
      @(negedge clk); bus_idle();
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      strap_kb_n = ~kb_n; strap_rtc_n = ~rtc_n; strap_cfg_hi = ~cfg_hi; strap_rom_en = ~rom;
      @(negedge clk);
   endtask

   task automatic t_keyboard_mode();
      cfg_lowio_en = 1'b0; cfg_rom_en = 1'b0;
      reset_with(1'b0, 1'b1, 1'b1, 1'b0);
      io_rd(20'h00060); check("R3", "kbd 60h read", V_KB);
      io_wr(20'h00064); check("R3", "kbd 64h write", V_KB);
      io_rd(20'h00062); check("R3", "mouse 62h", V_MC);
      io_wr(20'h00066); check("R3", "mouse 66h", V_MC);
      io_rd(20'h00061); check("R3", "61h no select", V_IDLE);
      io_rd(20'h00080); check("R4", "80h with keyboard on", V_IDLE);
      io_rd(20'h00070); check("R5", "rtc strap off", V_IDLE);
      io_rd(20'h0004E); check("R7", "cfg 4Eh", V_CFG);
      io_wr(20'h0004F); check("R7", "cfg 4Fh", V_CFG);
      io_rd(20'h0002E); check("R7", "2Eh not cfg", V_IDLE);
      io_rd(20'h01060); check("R9", "full 16-bit compare", V_IDLE);
      mem_rd(20'hF0000); check("R8", "rom disabled", V_IDLE);
      cfg_rom_en = 1'b1;
      mem_rd(20'hF0000); check("R8", "rom via config bit", V_ROM);
      cfg_rom_en = 1'b0;
      @(negedge clk); bus_idle();
   endtask

   task automatic t_legacy_mode();
      cfg_lowio_en = 1'b0; cfg_rom_en = 1'b0;
      reset_with(1'b1, 1'b0, 1'b0, 1'b1);
      io_rd(20'h00080); check("R4", "post port 80h", V_P80);
      io_rd(20'h00060); check("R4", "kbd off", V_IDLE);
      io_rd(20'h00066); check("R4", "mouse off", V_IDLE);
      io_rd(20'h00070); check("R5", "rtc 70h", V_RTC);
      io_wr(20'h00071); check("R5", "rtc 71h", V_RTC);
      io_rd(20'h00072); check("R5", "72h no select", V_IDLE);
      io_rd(20'h0002E); check("R7", "cfg 2Eh", V_CFG);
      io_rd(20'h0002F); check("R7", "cfg 2Fh", V_CFG);
      io_rd(20'h0004E); check("R7", "4Eh not cfg", V_IDLE);
      mem_rd(20'hF0000); check("R8", "rom low edge", V_ROM);
      mem_rd(20'hFFFFF); check("R8", "rom high edge", V_ROM);
      mem_rd(20'hEFFFF); check("R8", "below rom window", V_IDLE);
      io_rd(20'hF0080); check("R10", "io in rom window", V_P80);
      io_rd(20'hF0000); check("R10", "io at rom base", V_IDLE);
      @(negedge clk); bus_idle();
   endtask

   task automatic t_qualifiers();
      access(20'h00080, 1'b1, 1'b0, 1'b1, 1'b1);
      check("R9", "aen high blocks", V_IDLE);
      access(20'h00080, 1'b0, 1'b1, 1'b1, 1'b1);
      check("R9", "no strobe", V_IDLE);
      access(20'h00070, 1'b0, 1'b1, 1'b1, 1'b0);
      check("R9", "mem read to rtc port", V_IDLE);
      @(negedge clk); bus_idle();
   endtask

   task automatic t_lowio();
      cfg_lowio_en = 1'b1;
      io_rd(20'h00300); check("R6", "low window 300h", V_LOW);
      io_wr(20'h007FF); check("R6", "low window top", V_LOW);
      io_rd(20'h00800); check("R6", "above window", V_IDLE);
      io_rd(20'h00080); check("R6", "with post port", V_P80 & V_LOW);
      access(20'h00300, 1'b1, 1'b0, 1'b1, 1'b1);
      check("R6", "low window aen high", V_IDLE);
      cfg_lowio_en = 1'b0;
      io_rd(20'h00300); check("R6", "window disabled", V_IDLE);
      @(negedge clk); bus_idle();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      t_keyboard_mode();
      t_legacy_mode();
      t_qualifiers();
      t_lowio();
      // R2: fresh capture on a second reset with opposite straps
      t_keyboard_mode();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule